// File: doc/BRIEF.md
# Calendar Alarm Comparator with Repeat Counter

This block watches a running calendar clock and raises alarm events when the clock reaches a programmed alarm instant. The clock value arrives as BCD fields: a half-second phase flag, seconds, minutes, hours, weekday, day of month and month. A half-second tick strobe marks the cycles in which that value has just advanced. A 4-bit interval code selects which fields must agree with the stored alarm value. The available intervals run from every half second up to once a year.

A repeat counter sets how many alarms occur before the block disables itself. The counter is decremented after each alarm. When an alarm is issued with the counter already at zero, that alarm is the last one and the enable bit clears. In chime mode the counter wraps from zero to all ones instead, so alarms continue without end. Each alarm event produces a one-cycle interrupt pulse and flips a square-wave output. That output therefore runs at half the alarm rate, in the clock domain of the block.

Software programs the block through a small write port. The port has four word-wide slots: one for configuration and three for the alarm value.

Top module: `rtc_alarm`

## Requirements
- R1: While rst_ni is low, alarm_en_o, alarm_irq_o and alarm_pulse_o are 0, and the chime bit and repeat count are cleared.
- R2: An alarm event happens only in a cycle where tick_i is 1, the enable bit is 1 and the selected fields match. Without tick_i, a matching clock value produces no event.
- R3: The interval codes select these conditions. 0 matches every tick. 1 needs half=0. 2 needs half=0 and the seconds ones digit equal. 3 needs half=0 and the seconds equal. 4 adds the minutes ones digit to code 3. 5 needs half=0 plus equal seconds and minutes. 6 adds hours to code 5. 7 adds weekday to code 6. 8 adds day of month to code 6. 9 adds day and month to code 6.
- R4: Interval codes 10 to 15 never produce an event.
- R5: After each event the repeat count drops by one. An event taken with the count at 0 is the last one: the enable bit clears, and further matches raise nothing.
- R6: With chime set, an event taken at count 0 reloads the count with all ones. The enable bit stays set.
- R7: alarm_irq_o is high for exactly the one cycle after the clock edge that samples the event.
- R8: alarm_pulse_o inverts on every event and holds its value otherwise.
- R9: A write to slots 1 to 3 is ignored while the enable bit is set. A write to slot 0 takes effect at any time, and it wins over an event in the same cycle.
- R10: A yearly alarm (code 9) set for month 02 day 29 fires only when the clock reads month 02 day 29. It never fires on another date.
- R11: Write slots are selected by wr_sel_i. Slot 0: bit 15 enable, bit 14 chime, bits 11:8 interval code, bits 7:0 repeat count. Slot 1: bits 7:0 seconds, bits 15:8 minutes. Slot 2: bits 7:0 hours, bits 10:8 weekday. Slot 3: bits 7:0 day, bits 15:8 month.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Half-second strobe: clock value has just advanced |
| cur_half_i | input | 1 | Half-second phase, 0 on whole seconds |
| cur_sec_i | input | 8 | Current seconds, BCD |
| cur_min_i | input | 8 | Current minutes, BCD |
| cur_hour_i | input | 8 | Current hours, BCD |
| cur_wday_i | input | 3 | Current weekday |
| cur_day_i | input | 8 | Current day of month, BCD |
| cur_mon_i | input | 8 | Current month, BCD |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write slot select |
| wr_data_i | input | 16 | Write data |
| alarm_irq_o | output | 1 | One-cycle alarm interrupt |
| alarm_pulse_o | output | 1 | Square wave that flips on each alarm |
| alarm_en_o | output | 1 | Alarm enable state |

## Verification
The hardest situations to reach are the end of a repeat run and the chime wrap. Reaching either needs a chain of matching ticks while the alarm stays enabled. Directed sequences handle this. They program a small repeat count with the every-half-second code, then tick through to the final alarm, and then tick past it. In chime mode they run more than 256 ticks to cross the wrap. Random phases produce matches for the selective codes by copying the stored alarm fields into the clock inputs and then disturbing one field. This covers both the hit and the near-miss of each code.

// File: rtl/rtca_pkg.sv
package rtca_pkg;
  localparam int WDAY_W = 3;

  typedef struct packed {
    logic [7:0]        mon;
    logic [7:0]        day;
    logic [WDAY_W-1:0] wday;
    logic [7:0]        hour;
    logic [7:0]        min;
    logic [7:0]        sec;
  } rtca_time_t;

  // field requirement bits
  localparam int F_WHOLE = 0;
  localparam int F_SLO   = 1;
  localparam int F_SHI   = 2;
  localparam int F_MLO   = 3;
  localparam int F_MHI   = 4;
  localparam int F_HOUR  = 5;
  localparam int F_WDAY  = 6;
  localparam int F_DAY   = 7;
  localparam int F_MON   = 8;
  localparam int NFIELD  = 9;

  typedef enum logic [3:0] {
    IV_HALF = 4'd0, IV_SEC  = 4'd1, IV_10S = 4'd2, IV_MIN  = 4'd3,
    IV_10M  = 4'd4, IV_HOUR = 4'd5, IV_DAY = 4'd6, IV_WEEK = 4'd7,
    IV_MON  = 4'd8, IV_YEAR = 4'd9
  } rtca_iv_e;

  function automatic logic [NFIELD-1:0] field_req(input logic [3:0] code);
    logic [NFIELD-1:0] r;
    r = '0;
    if (code >= 4'd1 && code <= 4'd9) r[F_WHOLE] = 1'b1;
    if (code >= 4'd2 && code <= 4'd9) r[F_SLO]   = 1'b1;
    if (code >= 4'd3 && code <= 4'd9) r[F_SHI]   = 1'b1;
    if (code >= 4'd4 && code <= 4'd9) r[F_MLO]   = 1'b1;
    if (code >= 4'd5 && code <= 4'd9) r[F_MHI]   = 1'b1;
    if (code >= 4'd6 && code <= 4'd9) r[F_HOUR]  = 1'b1;
    if (code == 4'd7)                 r[F_WDAY]  = 1'b1;
    if (code == 4'd8 || code == 4'd9) r[F_DAY]   = 1'b1;
    if (code == 4'd9)                 r[F_MON]   = 1'b1;
    return r;
  endfunction

  function automatic logic code_valid(input logic [3:0] code);
    return code <= 4'd9;
  endfunction
endpackage

// File: rtl/rtca_aval.sv
module rtca_aval
  import rtca_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        sel_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              lock_i,
  output rtca_time_t        alarm_o
);
  rtca_time_t val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q <= '0;
    end else if (we_i && !lock_i) begin
      unique case (sel_i)
        2'd1: begin
          val_q.sec <= data_i[7:0];
          val_q.min <= data_i[15:8];
        end
        2'd2: begin
          val_q.hour <= data_i[7:0];
          val_q.wday <= data_i[8 +: WDAY_W];
        end
        2'd3: begin
          val_q.day <= data_i[7:0];
          val_q.mon <= data_i[15:8];
        end
        default: ;
      endcase
    end
  end

  assign alarm_o = val_q;
endmodule

// File: rtl/rtca_match.sv
module rtca_match
  import rtca_pkg::*;
(
  input  logic       [3:0] code_i,
  input  logic             half_i,
  input  rtca_time_t       cur_i,
  input  rtca_time_t       alm_i,
  output logic             hit_o
);
  logic [NFIELD-1:0] eq;
  logic [NFIELD-1:0] req;

  // per-digit compare of the seconds and minutes bytes
  localparam int NDIG = 4;
  logic [NDIG-1:0][3:0] cur_dig, alm_dig;
  assign cur_dig = {cur_i.min, cur_i.sec};
  assign alm_dig = {alm_i.min, alm_i.sec};

  for (genvar g = 0; g < NDIG; g++) begin : g_dig
    assign eq[F_SLO + g] = (cur_dig[g] == alm_dig[g]);
  end

  assign eq[F_WHOLE] = ~half_i;
  assign eq[F_HOUR]  = (cur_i.hour == alm_i.hour);
  assign eq[F_WDAY]  = (cur_i.wday == alm_i.wday);
  assign eq[F_DAY]   = (cur_i.day  == alm_i.day);
  assign eq[F_MON]   = (cur_i.mon  == alm_i.mon);

  assign req   = field_req(code_i);
  assign hit_o = code_valid(code_i) && (&(eq | ~req));
endmodule

// File: rtl/rtca_ctrl.sv
module rtca_ctrl #(
  parameter int REP_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic             cfg_en_i,
  input  logic             cfg_chime_i,
  input  logic [3:0]       cfg_code_i,
  input  logic [REP_W-1:0] cfg_rpt_i,
  input  logic             hit_i,
  input  logic             tick_i,
  output logic             en_o,
  output logic [3:0]       code_o,
  output logic             irq_o,
  output logic             pulse_o
);
  localparam logic [REP_W-1:0] RPT_MAX = {REP_W{1'b1}};

  logic             en_q, chime_q, irq_q, pulse_q;
  logic [3:0]       code_q;
  logic [REP_W-1:0] rpt_q;
  logic             evt;

  assign evt = tick_i & en_q & hit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      chime_q <= 1'b0;
      code_q  <= '0;
      rpt_q   <= '0;
    end else if (cfg_we_i) begin
      en_q    <= cfg_en_i;
      chime_q <= cfg_chime_i;
      code_q  <= cfg_code_i;
      rpt_q   <= cfg_rpt_i;
    end else if (evt) begin
      if (rpt_q == '0) begin
        if (chime_q) rpt_q <= RPT_MAX;
        else         en_q  <= 1'b0;
      end else begin
        rpt_q <= rpt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      irq_q <= evt;
      if (evt) pulse_q <= ~pulse_q;
    end
  end

  assign en_o    = en_q;
  assign code_o  = code_q;
  assign irq_o   = irq_q;
  assign pulse_o = pulse_q;
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm
  import rtca_pkg::*;
#(
  parameter int REP_W  = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              cur_half_i,
  input  logic [7:0]        cur_sec_i,
  input  logic [7:0]        cur_min_i,
  input  logic [7:0]        cur_hour_i,
  input  logic [WDAY_W-1:0] cur_wday_i,
  input  logic [7:0]        cur_day_i,
  input  logic [7:0]        cur_mon_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              alarm_irq_o,
  output logic              alarm_pulse_o,
  output logic              alarm_en_o
);
  localparam int EN_BIT    = DATA_W - 1;
  localparam int CHIME_BIT = DATA_W - 2;

  rtca_time_t cur, alm;
  logic [3:0] code;
  logic       hit, en, cfg_we;
  logic [1:0] unused_cfg;

  assign cur        = '{mon: cur_mon_i, day: cur_day_i, wday: cur_wday_i,
                        hour: cur_hour_i, min: cur_min_i, sec: cur_sec_i};
  assign cfg_we     = wr_en_i && (wr_sel_i == 2'd0);
  assign unused_cfg = wr_data_i[13:12];

  rtca_aval #(.DATA_W(DATA_W)) u_aval (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (wr_en_i),
    .sel_i  (wr_sel_i),
    .data_i (wr_data_i),
    .lock_i (en),
    .alarm_o(alm)
  );

  rtca_match u_match (
    .code_i(code),
    .half_i(cur_half_i),
    .cur_i (cur),
    .alm_i (alm),
    .hit_o (hit)
  );

  rtca_ctrl #(.REP_W(REP_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_we_i   (cfg_we),
    .cfg_en_i   (wr_data_i[EN_BIT]),
    .cfg_chime_i(wr_data_i[CHIME_BIT]),
    .cfg_code_i (wr_data_i[11:8]),
    .cfg_rpt_i  (wr_data_i[REP_W-1:0]),
    .hit_i      (hit),
    .tick_i     (tick_i),
    .en_o       (en),
    .code_o     (code),
    .irq_o      (alarm_irq_o),
    .pulse_o    (alarm_pulse_o)
  );

  assign alarm_en_o = en;
endmodule

// File: rtl/rtc_alarm_chk.sv
module rtc_alarm_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        tick_i,
  input logic        wr_en_i,
  input logic [1:0]  wr_sel_i,
  input logic [15:0] wr_data_i,
  input logic        alarm_irq_o,
  input logic        alarm_pulse_o,
  input logic        alarm_en_o
);
  // R1
  reset_clear_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (!alarm_en_o && !alarm_irq_o && !alarm_pulse_o));

  // R2
  irq_needs_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_irq_o |-> $past(tick_i) && $past(alarm_en_o));

  // R8
  pulse_flip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_irq_o |-> alarm_pulse_o != $past(alarm_pulse_o));

  // R8
  pulse_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !alarm_irq_o |-> $stable(alarm_pulse_o));

  // R9
  en_rise_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(alarm_en_o) |-> $past(wr_en_i && wr_sel_i == 2'd0 && wr_data_i[15]));
endmodule

bind rtc_alarm rtc_alarm_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .tick_i       (tick_i),
  .wr_en_i      (wr_en_i),
  .wr_sel_i     (wr_sel_i),
  .wr_data_i    (wr_data_i),
  .alarm_irq_o  (alarm_irq_o),
  .alarm_pulse_o(alarm_pulse_o),
  .alarm_en_o   (alarm_en_o)
);

// File: tb/tb_rtc_alarm.sv
module tb_rtc_alarm;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic        cur_half_i = 1'b0;
  logic [7:0]  cur_sec_i = '0, cur_min_i = '0, cur_hour_i = '0;
  logic [2:0]  cur_wday_i = '0;
  logic [7:0]  cur_day_i = '0, cur_mon_i = '0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_sel_i = '0;
  logic [15:0] wr_data_i = '0;
  logic        alarm_irq_o, alarm_pulse_o, alarm_en_o;

  int checks = 0;
  int failures = 0;

  // reference state
  logic       m_en = 0, m_chime = 0, m_pulse = 0, m_irq = 0;
  logic [3:0] m_code = 0;
  logic [7:0] m_rpt = 0;
  logic [7:0] a_sec = 0, a_min = 0, a_hour = 0, a_day = 0, a_mon = 0;
  logic [2:0] a_wday = 0;

  always #5 clk_i = ~clk_i;

  rtc_alarm dut (.*);

  initial begin
    #1_500_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  function automatic logic ref_hit(input logic [3:0] c);
    logic s, m, h;
    s = !cur_half_i && cur_sec_i == a_sec;
    m = cur_min_i == a_min;
    h = cur_hour_i == a_hour;
    case (c)
      4'd0: return 1'b1;
      4'd1: return !cur_half_i;
      4'd2: return !cur_half_i && cur_sec_i[3:0] == a_sec[3:0];
      4'd3: return s;
      4'd4: return s && cur_min_i[3:0] == a_min[3:0];
      4'd5: return s && m;
      4'd6: return s && m && h;
      4'd7: return s && m && h && cur_wday_i == a_wday;
      4'd8: return s && m && h && cur_day_i == a_day;
      4'd9: return s && m && h && cur_day_i == a_day && cur_mon_i == a_mon;
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(input string req, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  // one cycle; inputs already set; advance reference, then compare at negedge
  task automatic cyc(input string req);
    logic evt;
    evt = tick_i && m_en && ref_hit(m_code);
    if (wr_en_i) begin
      if (wr_sel_i == 0) begin
        m_en = wr_data_i[15]; m_chime = wr_data_i[14];
        m_code = wr_data_i[11:8]; m_rpt = wr_data_i[7:0];
      end else if (!m_en) begin
        case (wr_sel_i)
          2'd1: begin a_sec = wr_data_i[7:0]; a_min = wr_data_i[15:8]; end
          2'd2: begin a_hour = wr_data_i[7:0]; a_wday = wr_data_i[10:8]; end
          default: begin a_day = wr_data_i[7:0]; a_mon = wr_data_i[15:8]; end
        endcase
      end
    end else if (evt) begin
      if (m_rpt == 0) begin
        if (m_chime) m_rpt = 8'hFF; else m_en = 0;
      end else m_rpt--;
    end
    m_irq = evt;
    if (evt) m_pulse = ~m_pulse;
    @(posedge clk_i);
    @(negedge clk_i);
    tick_i = 0; wr_en_i = 0;
    chk(req, alarm_irq_o, m_irq, "irq");
    chk(req, alarm_pulse_o, m_pulse, "pulse");
    chk(req, alarm_en_o, m_en, "en");
  endtask

  task automatic wr(input logic [1:0] s, input logic [15:0] d, input string req);
    wr_en_i = 1; wr_sel_i = s; wr_data_i = d;
    cyc(req);
  endtask

  task automatic cfg(input logic en, input logic ch, input logic [3:0] c,
                     input logic [7:0] r, input string req);
    wr(2'd0, {en, ch, 2'b00, c, r}, req);
  endtask

  task automatic set_time(input logic h, input logic [7:0] s, input logic [7:0] mi,
                          input logic [7:0] hr, input logic [2:0] wd,
                          input logic [7:0] d, input logic [7:0] mo);
    cur_half_i = h; cur_sec_i = s; cur_min_i = mi; cur_hour_i = hr;
    cur_wday_i = wd; cur_day_i = d; cur_mon_i = mo;
  endtask

  task automatic tick(input string req);
    tick_i = 1;
    cyc(req);
  endtask

  task automatic set_alarm(input string req);
    wr(2'd1, {8'h34, 8'h56}, req);
    wr(2'd2, {5'b0, 3'd4, 8'h12}, req);
    wr(2'd3, {8'h07, 8'h15}, req);
  endtask

  initial begin
    void'($urandom(32'h5eed));
    // R1: reset state
    repeat (3) @(negedge clk_i);
    chk("R1", alarm_en_o, 0, "en in reset");
    chk("R1", alarm_irq_o, 0, "irq in reset");
    chk("R1", alarm_pulse_o, 0, "pulse in reset");
    rst_ni = 1;
    @(negedge clk_i);

    // R11/R3: alarm value 07-15 wd4 12:34:56, exact and near-miss for each code
    set_alarm("R11");
    for (int c = 1; c <= 9; c++) begin
      cfg(1, 1, c[3:0], 8'd5, "R3");
      set_time(0, 8'h56, 8'h34, 8'h12, 3'd4, 8'h15, 8'h07);
      tick("R3");
      set_time(1, 8'h56, 8'h34, 8'h12, 3'd4, 8'h15, 8'h07);
      tick("R3");
      set_time(0, 8'h46, 8'h34, 8'h12, 3'd4, 8'h15, 8'h07);
      tick("R3");
      set_time(0, 8'h56, 8'h24, 8'h12, 3'd4, 8'h15, 8'h07);
      tick("R3");
      set_time(0, 8'h56, 8'h34, 8'h12, 3'd2, 8'h16, 8'h08);
      tick("R3");
    end

    // R2: match without tick gives nothing
    cfg(1, 0, 4'd0, 8'd3, "R2");
    repeat (3) cyc("R2");

    // R4: invalid codes never match
    for (int c = 10; c <= 15; c++) begin
      cfg(1, 0, c[3:0], 8'd3, "R4");
      set_time(0, 8'h56, 8'h34, 8'h12, 3'd4, 8'h15, 8'h07);
      tick("R4");
    end

    // R5/R7: count 2 gives three alarms then self-disable
    cfg(1, 0, 4'd0, 8'd2, "R5");
    repeat (3) begin tick("R7"); cyc("R7"); end
    chk("R5", alarm_en_o, 0, "disabled after last");
    tick("R5");
    chk("R5", alarm_irq_o, 0, "no alarm after disable");

    // R6: chime wraps through 0 and keeps going past 256 events
    cfg(1, 1, 4'd0, 8'd1, "R6");
    repeat (300) tick("R6");
    chk("R6", alarm_en_o, 1, "chime still enabled");

    // R9: alarm value writes locked while enabled
    cfg(1, 0, 4'd3, 8'd9, "R9");
    wr(2'd1, {8'h00, 8'h11}, "R9");
    set_time(0, 8'h11, 8'h00, 8'h00, 3'd0, 8'h01, 8'h01);
    tick("R9");
    chk("R9", alarm_irq_o, 0, "locked write ignored");
    set_time(0, 8'h56, 8'h34, 8'h00, 3'd0, 8'h01, 8'h01);
    tick("R9");
    chk("R9", alarm_irq_o, 1, "old seconds still match");

    // R10: yearly on Feb 29
    cfg(0, 0, 4'd9, 8'd9, "R10");
    wr(2'd1, 16'h0000, "R10");
    wr(2'd2, 16'h0000, "R10");
    wr(2'd3, {8'h02, 8'h29}, "R10");
    cfg(1, 0, 4'd9, 8'd9, "R10");
    set_time(0, 8'h00, 8'h00, 8'h00, 3'd1, 8'h28, 8'h02); tick("R10");
    set_time(0, 8'h00, 8'h00, 8'h00, 3'd2, 8'h01, 8'h03); tick("R10");
    set_time(0, 8'h00, 8'h00, 8'h00, 3'd3, 8'h29, 8'h03); tick("R10");
    set_time(0, 8'h00, 8'h00, 8'h00, 3'd4, 8'h29, 8'h02); tick("R10");
    chk("R10", alarm_irq_o, 1, "Feb 29 hit");

    // random phase
    for (int i = 0; i < 3000; i++) begin
      int op;
      op = $urandom_range(0, 19);
      if (op == 0)
        cfg($urandom_range(0, 3) != 0, $urandom_range(0, 1), $urandom_range(0, 15),
            $urandom_range(0, 6), "R3");
      else if (op == 1)
        wr($urandom_range(1, 3), $urandom, "R9");
      else begin
        set_time($urandom_range(0, 1), a_sec, a_min, a_hour, a_wday, a_day, a_mon);
        case ($urandom_range(0, 7))
          0: cur_sec_i[3:0] = $urandom_range(0, 9);
          1: cur_sec_i[7:4] = $urandom_range(0, 5);
          2: cur_min_i[3:0] = $urandom_range(0, 9);
          3: cur_min_i[7:4] = $urandom_range(0, 5);
          4: cur_hour_i = $urandom_range(0, 35);
          5: cur_wday_i = $urandom_range(0, 6);
          6: begin cur_day_i = $urandom_range(1, 49); cur_mon_i = $urandom_range(1, 18); end
          default: ;
        endcase
        if ($urandom_range(0, 3) == 0) cyc("R2"); else tick("R3");
      end
    end

    // R1: reset mid-run clears state
    cfg(1, 0, 4'd0, 8'd9, "R1");
    tick("R1");
    rst_ni = 0;
    m_en = 0; m_pulse = 0; m_irq = 0; m_chime = 0; m_rpt = 0; m_code = 0;
    #2;
    chk("R1", alarm_en_o, 0, "en after reset");
    chk("R1", alarm_pulse_o, 0, "pulse after reset");
    @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    tick("R1");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule